// File: doc/BRIEF.md
# Video Encoder Control-Register I2C Slave

This block is the write-only control port of a video encoder. It sits on a two-wire serial bus as a target device and holds four 8-bit control registers at subaddresses 0 to 3. A host writes a transaction in this order: its 7-bit device address with the direction bit, then a subaddress byte, then one or more data bytes. The subaddress advances by one after each data byte that is accepted. The block answers only write requests to its own address. It withholds the acknowledge for a read request, for a foreign address, and for a subaddress outside the bank.

Most register bits act as soon as their byte is acknowledged. Bits that would visibly disturb the picture in the middle of a frame are double-buffered. These are the black-level bit and the two overlay-level bits. A write to them lands in a shadow copy, and the live copy takes the shadow value on a strobe that marks the start of vertical blanking. Register 0 also chooses where the 4-bit operating mode comes from: either external mode pins or its own low nibble.

Both bus lines are synchronised into the system clock, which must run at least eight times faster than SCL. The data line is modelled as an input plus a pull-low enable.

Top module: `vid_i2c_regbank`

## Requirements
- R1: After a synchronous reset every register output reads 0 and sda_pull_o is 0.
- R2: A write whose address byte is 0x88 (7-bit address 0x44, direction bit 0) is acknowledged on the address byte, on a subaddress byte of 0 to 3, and on each in-range data byte. The acknowledged data byte appears on that register's output.
- R3: Consecutive data bytes of one transaction go to consecutive subaddresses, starting at the written subaddress.
- R4: An address byte other than 0x88 or 0x89 is not acknowledged, and no register changes for the rest of that transaction.
- R5: An address byte of 0x89 (a read request to this device) is not acknowledged, and no register changes.
- R6: A subaddress byte of 4 or more is not acknowledged, and data bytes that follow it in the same transaction are neither acknowledged nor written.
- R7: A data byte whose advanced subaddress has passed 3 is not acknowledged and writes nothing. Bytes already acknowledged in the same transaction stay written.
- R8: Bits [7:4] of register 3 always read 0, whatever value is written.
- R9: Register 1 bit 1 and register 2 bits [1:0] keep their live value after a write. They take the most recently written value in the cycle after vblank_stb is high. The other bits of the same registers update immediately.
- R10: When register 0 bit 7 is 1, mode_o equals register 0 bits [3:0]. Otherwise mode_o equals ext_mode_i.
- R11: A start condition in the middle of a transaction restarts decoding from the address byte. Writes acknowledged before it are kept.
- R12: sda_pull_o is driven only during an acknowledge bit. It rises and falls only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | Pull-low enable for the data line (acknowledge) |
| vblank_stb | input | 1 | One-cycle strobe at the start of vertical blanking |
| ext_mode_i | input | 4 | Operating mode from external pins |
| mode_o | output | 4 | Selected operating mode |
| reg0_o | output | 8 | Live register at subaddress 0 |
| reg1_o | output | 8 | Live register at subaddress 1 |
| reg2_o | output | 8 | Live register at subaddress 2 |
| reg3_o | output | 8 | Live register at subaddress 3 (upper nibble 0) |

## Verification
The bench drives transactions that are wrong in different ways, and after each one it checks the acknowledge bit and the whole register bank.
- A wrong address or a read request must draw no acknowledge. A slave that decodes only part of the address byte would acknowledge it and corrupt registers.
- A subaddress past the end must be refused. A burst that runs past register 3 must stop writing there. A subaddress pointer that wraps instead of refusing would overwrite register 0.
- The deferred fields are checked both before and after the blanking strobe. A design that applies them at once, or copies the whole register on the strobe, shows the wrong value in one of the two samples.
- A repeated start that goes unnoticed would treat the new address byte as data.

// File: rtl/vid_i2c_pkg.sv
package vid_i2c_pkg;
    localparam int NREGS    = 4;
    localparam int DW       = 8;
    localparam int AW       = $clog2(NREGS);
    localparam logic [6:0] DEV_ADDR = 7'h44;

    typedef logic [DW-1:0] byte_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RECV,
        PH_ACK,
        PH_IGNORE
    } phase_e;

    typedef enum logic [1:0] {
        BY_ADDR,
        BY_SUB,
        BY_DATA
    } byte_kind_e;

    // Bits that exist in register idx
    function automatic byte_t impl_mask(int idx);
        return (idx == 3) ? byte_t'(8'h0F) : byte_t'(8'hFF);
    endfunction

    // Bits of register idx applied only at vertical blanking
    function automatic byte_t defer_mask(int idx);
        if (idx == 1) return byte_t'(8'h02);
        if (idx == 2) return byte_t'(8'h03);
        return byte_t'(8'h00);
    endfunction
endpackage

// File: rtl/vid_i2c_sync.sv
module vid_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_pipe[STAGES-1] & ~scl_d;
    assign scl_fall  = ~scl_pipe[STAGES-1] & scl_d;
    assign start_det = scl_pipe[STAGES-1] & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_pipe[STAGES-1] & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/vid_i2c_engine.sv
module vid_i2c_engine
    import vid_i2c_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    output logic          sda_pull,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output byte_t         wr_data
);
    phase_e     phase;
    byte_kind_e kind;
    byte_t      shreg;
    logic [3:0] bitcnt;
    byte_t      ptr;

    logic  byte_full;
    logic  accept;
    assign byte_full = (bitcnt == 4'd8);

    always_comb begin
        unique case (kind)
            BY_ADDR: accept = (shreg == {DEV_ADDR, 1'b0});
            BY_SUB:  accept = (shreg < byte_t'(NREGS));
            default: accept = (ptr < byte_t'(NREGS));
        endcase
    end

    always_ff @(posedge clk) begin
        wr_en <= 1'b0;
        if (rst) begin
            phase    <= PH_IDLE;
            kind     <= BY_ADDR;
            shreg    <= '0;
            bitcnt   <= '0;
            ptr      <= '0;
            sda_pull <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (start_det) begin
            phase    <= PH_RECV;
            kind     <= BY_ADDR;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end else if (stop_det) begin
            phase    <= PH_IDLE;
            sda_pull <= 1'b0;
        end else begin
            unique case (phase)
                PH_RECV: begin
                    if (scl_rise && !byte_full) begin
                        shreg  <= {shreg[DW-2:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && byte_full) begin
                        if (accept) begin
                            phase    <= PH_ACK;
                            sda_pull <= 1'b1;
                            if (kind == BY_SUB) ptr <= shreg;
                            if (kind == BY_DATA) begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr[AW-1:0];
                                wr_data <= shreg;
                                ptr     <= ptr + byte_t'(1);
                            end
                        end else begin
                            phase <= PH_IGNORE;
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        sda_pull <= 1'b0;
                        phase    <= PH_RECV;
                        bitcnt   <= '0;
                        kind     <= (kind == BY_ADDR) ? BY_SUB : BY_DATA;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vid_i2c_regfile.sv
module vid_i2c_regfile
    import vid_i2c_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    input  logic          vblank_stb,
    output byte_t         live [NREGS]
);
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam byte_t IMPL = impl_mask(g);
        localparam byte_t DEF  = defer_mask(g);
        byte_t shadow, shadow_nxt, live_q, live_nxt;
        logic  hit;

        assign hit = wr_en && (wr_addr == AW'(g));

        always_comb begin
            shadow_nxt = hit ? (wr_data & IMPL) : shadow;
            live_nxt   = live_q;
            if (hit)        live_nxt = (shadow_nxt & ~DEF) | (live_q & DEF);
            if (vblank_stb) live_nxt = (live_nxt & ~DEF) | (shadow_nxt & DEF);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow <= '0;
                live_q <= '0;
            end else begin
                shadow <= shadow_nxt;
                live_q <= live_nxt;
            end
        end

        assign live[g] = live_q;
    end
endmodule

// File: rtl/vid_i2c_regbank.sv
module vid_i2c_regbank
    import vid_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic       vblank_stb,
    input  logic [3:0] ext_mode_i,
    output logic [3:0] mode_o,
    output logic [7:0] reg0_o,
    output logic [7:0] reg1_o,
    output logic [7:0] reg2_o,
    output logic [7:0] reg3_o
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en;
    logic [AW-1:0] wr_addr;
    byte_t wr_data;
    byte_t live [NREGS];

    vid_i2c_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    vid_i2c_engine u_engine (
        .clk(clk), .rst(rst), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_pull(sda_pull_o), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    vid_i2c_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vblank_stb(vblank_stb), .live(live)
    );

    assign reg0_o = live[0];
    assign reg1_o = live[1];
    assign reg2_o = live[2];
    assign reg3_o = live[3];
    assign mode_o = live[0][7] ? live[0][3:0] : ext_mode_i;
endmodule

// File: rtl/vid_i2c_regbank_chk.sv
module vid_i2c_regbank_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_pull_o,
    input logic       vblank_stb,
    input logic [7:0] reg0_o,
    input logic [7:0] reg1_o,
    input logic [7:0] reg2_o,
    input logic [7:0] reg3_o
);
    logic [31:0] bank;
    assign bank = {reg3_o, reg2_o, reg1_o, reg0_o};

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (bank == 32'h0 && !sda_pull_o));

    a_r8_upper_nibble_zero: assert property (@(posedge clk) disable iff (rst)
        reg3_o[7:4] == 4'h0);

    a_r9_deferred_hold: assert property (@(posedge clk) disable iff (rst)
        !vblank_stb |=> ($stable(reg1_o[1]) && $stable(reg2_o[1:0])));

    // R4: a register only changes on an acknowledged byte or at blanking
    a_r4_change_needs_ack: assert property (@(posedge clk) disable iff (rst)
        ((bank != $past(bank)) && !$past(vblank_stb)) |-> sda_pull_o);

    a_r12_pull_rise_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !scl_i);

    a_r12_pull_fall_scl_low: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_pull_o) |-> !scl_i);
endmodule

bind vid_i2c_regbank vid_i2c_regbank_chk u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
    .vblank_stb(vblank_stb), .reg0_o(reg0_o), .reg1_o(reg1_o),
    .reg2_o(reg2_o), .reg3_o(reg3_o)
);

// File: tb/vid_i2c_regbank_bench.sv
module vid_i2c_regbank_bench;
    localparam int Q = 10;  // clock cycles per quarter SCL period

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic vblank_stb = 1'b0;
    logic [3:0] ext_mode_i = 4'hA;
    logic sda_pull_o;
    logic [3:0] mode_o;
    logic [7:0] reg0_o, reg1_o, reg2_o, reg3_o;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_r [4];

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull_o;

    vid_i2c_regbank u_vid_i2c_regbank (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull_o(sda_pull_o), .vblank_stb(vblank_stb),
        .ext_mode_i(ext_mode_i), .mode_o(mode_o),
        .reg0_o(reg0_o), .reg1_o(reg1_o), .reg2_o(reg2_o), .reg3_o(reg3_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_bank(string req);
        chk(req, {reg3_o, reg2_o, reg1_o, reg0_o},
            {exp_r[3], exp_r[2], exp_r[1], exp_r[0]});
    endtask

    task automatic wait_q(int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q(2);
    endtask

    task automatic send_byte(logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q();
            scl_m = 1'b1; wait_q(2);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        acked = ~sda_bus;
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic pulse_vblank();
        @(negedge clk) vblank_stb = 1'b1;
        @(negedge clk) vblank_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 regs zero", {reg3_o, reg2_o, reg1_o, reg0_o}, 32'h0);
        chk("R1 pull low", sda_pull_o, 1'b0);
        chk("R10 ext mode at reset", mode_o, 4'hA);
    endtask

    task automatic t_single_write();
        logic a;
        bus_start();
        send_byte(8'h88, a); chk("R2 addr ack", a, 1'b1);
        send_byte(8'h00, a); chk("R2 sub ack", a, 1'b1);
        send_byte(8'h85, a); chk("R2 data ack", a, 1'b1);
        bus_stop();
        exp_r[0] = 8'h85;
        chk_bank("R2 reg0 written");
        chk("R10 internal mode", mode_o, 4'h5);
        chk("R12 pull released", sda_pull_o, 1'b0);
        bus_start();
        send_byte(8'h88, a);
        send_byte(8'h00, a);
        send_byte(8'h05, a);
        bus_stop();
        exp_r[0] = 8'h05;
        chk("R10 external mode", mode_o, 4'hA);
    endtask

    task automatic t_burst();
        logic a;
        bus_start();
        send_byte(8'h88, a);
        send_byte(8'h01, a);
        send_byte(8'hF3, a); chk("R3 byte1 ack", a, 1'b1);
        send_byte(8'h5E, a); chk("R3 byte2 ack", a, 1'b1);
        send_byte(8'hAB, a); chk("R3 byte3 ack", a, 1'b1);
        bus_stop();
        exp_r[1] = 8'hF1; exp_r[2] = 8'h5C; exp_r[3] = 8'h0B;
        chk_bank("R3 R9 burst before blanking");
        chk("R8 upper nibble", reg3_o[7:4], 4'h0);
        pulse_vblank();
        exp_r[1] = 8'hF3; exp_r[2] = 8'h5E;
        chk_bank("R9 after blanking");
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte(8'h8A, a); chk("R4 foreign addr nack", a, 1'b0);
        send_byte(8'h00, a);
        send_byte(8'hFF, a);
        bus_stop();
        chk_bank("R4 bank unchanged");
    endtask

    task automatic t_read_req();
        logic a;
        bus_start();
        send_byte(8'h89, a); chk("R5 read nack", a, 1'b0);
        send_byte(8'h00, a);
        bus_stop();
        chk_bank("R5 bank unchanged");
    endtask

    task automatic t_bad_sub();
        logic a;
        bus_start();
        send_byte(8'h88, a);
        send_byte(8'h04, a); chk("R6 sub nack", a, 1'b0);
        send_byte(8'h77, a); chk("R6 data after bad sub nack", a, 1'b0);
        bus_stop();
        chk_bank("R6 bank unchanged");
    endtask

    task automatic t_past_end();
        logic a;
        bus_start();
        send_byte(8'h88, a);
        send_byte(8'h03, a);
        send_byte(8'h07, a); chk("R7 last reg ack", a, 1'b1);
        send_byte(8'h99, a); chk("R7 past end nack", a, 1'b0);
        bus_stop();
        exp_r[3] = 8'h07;
        chk_bank("R7 no wrap write");
    endtask

    task automatic t_restart();
        logic a;
        bus_start();
        send_byte(8'h88, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte(8'h88, a); chk("R11 addr after restart ack", a, 1'b1);
        send_byte(8'h02, a);
        send_byte(8'hA4, a);
        bus_stop();
        exp_r[2] = 8'hA6;
        chk_bank("R11 write after restart");
        pulse_vblank();
        exp_r[2] = 8'hA4;
        chk_bank("R9 R11 after blanking");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) exp_r[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_single_write();
        t_burst();
        t_wrong_addr();
        t_read_req();
        t_bad_sub();
        t_past_end();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule